// File: doc/BRIEF.md
# Single-Accumulator Execution Core

A small processor core built around one working register, the accumulator. Each instruction word carries an operation code and a single memory address. Arithmetic reads the word at that address, combines it with the accumulator and leaves the result in the accumulator. The accumulator is always the hidden second source and the destination. Two transfer operations move a word between memory and the accumulator. A halt code ends execution.

The core drives one synchronous, word-addressed memory port. A read returns its data on the cycle after the address is presented. Every instruction takes four states: fetch, decode, execute and writeback. The program counter then steps to the next word. No branches exist, so programs run in straight lines until they halt.

The memory port has a fixed latency and carries no valid/ready handshake. The memory may never stall, and it must answer every address one cycle later. The only other pins are the clock, the reset and the halt flag.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0. Asserting reset clears `halted` at once, without waiting for a clock edge.
- R2: An instruction word holds the operation code in bits [31:28] and the operand address in bits [27:0]. The codes are: 1 load, 2 store, 3 add, 4 subtract, 5 multiply and 15 halt.
- R3: Load places M[addr] into the accumulator.
- R4: Store writes the accumulator to M[addr], and `mem_we` is high for exactly one cycle per store.
- R5: Add sets the accumulator to the sum with M[addr], modulo 2^32.
- R6: Subtract sets the accumulator to the accumulator minus M[addr], modulo 2^32.
- R7: Multiply keeps the low 32 bits of the product of the accumulator and M[addr].
- R8: Each non-halt instruction takes exactly four cycles, and the next fetch comes from the following word. A program of N non-halt instructions followed by a halt raises `halted` exactly 4N+2 clock edges after reset is released.
- R9: Once halted, the core fetches nothing more, never writes memory and keeps `halted` high until reset.
- R10: Any unlisted operation code leaves the accumulator and memory unchanged, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 28 | Word address for fetch, load or store |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 32 | Accumulator value to be stored |
| mem_rdata | input | 32 | Word read from the previous cycle's address |
| halted | output | 1 | High after a halt instruction has been decoded |

## Verification
The assertions assume that the memory is a plain registered array. Under that assumption `mem_rdata` is always the word addressed one cycle earlier, it is never late, and reset is held for at least one edge. The bench attaches exactly such a memory. It loads each program only while reset is low, and it ends every program with a halt word. Unused memory holds a recognisable marker word, so a stray write or a fetch past the halt would show up in that memory.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h3;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_MUL   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_WB     = 3'd3,
    ST_HALT   = 3'd4
  } core_state_e;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] dec_op_i,
  output core_state_e      state_o
);
  core_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (dec_op_i == OPC_HALT) ? ST_HALT : ST_EXEC;
      ST_EXEC:   state_d = ST_WB;
      ST_WB:     state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HALT |=> state_q == ST_HALT); // R9
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OPC_W-1:0]  op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_acc_o
);
  always_comb begin
    res_o    = acc_i;
    wr_acc_o = 1'b0;
    case (op_i)
      OPC_LOAD: begin res_o = opnd_i;          wr_acc_o = 1'b1; end
      OPC_ADD:  begin res_o = acc_i + opnd_i;  wr_acc_o = 1'b1; end
      OPC_SUB:  begin res_o = acc_i - opnd_i;  wr_acc_o = 1'b1; end
      OPC_MUL:  begin res_o = acc_i * opnd_i;  wr_acc_o = 1'b1; end
      default:  begin res_o = acc_i;           wr_acc_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  core_state_e       state_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_wr_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [OPC_W-1:0]  ir_op_o,
  output logic [ADDR_W-1:0] ir_addr_o,
  output logic [DATA_W-1:0] acc_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (state_i == ST_DECODE) ir_q <= mem_rdata_i;
      if (state_i == ST_WB) begin
        pc_q <= pc_q + 1'b1;
        if (alu_wr_i) acc_q <= alu_res_i;
      end
    end
  end

  assign pc_o      = pc_q;
  assign ir_op_o   = ir_q[DATA_W-1 -: OPC_W];
  assign ir_addr_o = ir_q[ADDR_W-1:0];
  assign acc_o     = acc_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == ST_WB |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state_i != ST_WB |=> $stable(acc_q)); // R10
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int FIELD_W = DATA_W - OPC_W;

  core_state_e       state;
  logic [ADDR_W-1:0] pc;
  logic [OPC_W-1:0]  ir_op;
  logic [ADDR_W-1:0] ir_addr;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] alu_res;
  logic              alu_wr;

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_op_i (mem_rdata[DATA_W-1 -: OPC_W]),
    .state_o  (state)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .mem_rdata_i (mem_rdata),
    .alu_res_i   (alu_res),
    .alu_wr_i    (alu_wr),
    .pc_o        (pc),
    .ir_op_o     (ir_op),
    .ir_addr_o   (ir_addr),
    .acc_o       (acc)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i     (ir_op),
    .acc_i    (acc),
    .opnd_i   (mem_rdata),
    .res_o    (alu_res),
    .wr_acc_o (alu_wr)
  );

  always_comb begin
    mem_addr = pc;
    if (state == ST_EXEC || state == ST_WB) mem_addr = ir_addr;
  end

  assign mem_we    = (state == ST_EXEC) && (ir_op == OPC_STORE);
  assign mem_wdata = acc;
  assign halted    = (state == ST_HALT);

  initial begin
    AST_ADDR_FITS: assert (ADDR_W <= FIELD_W); // R2
  end

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R9
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R4
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr)); // R9
endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 28;
  localparam logic [31:0] MARK = 32'hA5A5_5A5A;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{4'h1, 32'd5,         32'd9,         32'd9},
    '{4'h3, 32'd7,         32'd8,         32'd15},
    '{4'h3, 32'hFFFF_FFFF, 32'd2,         32'd1},
    '{4'h4, 32'd10,        32'd3,         32'd7},
    '{4'h4, 32'd0,         32'd1,         32'hFFFF_FFFF},
    '{4'h5, 32'd6,         32'd7,         32'd42},
    '{4'h5, 32'h0001_0000, 32'h0001_0000, 32'd0},
    '{4'h5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1},
    '{4'h7, 32'd11,        32'd22,        32'd11}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              halted;

  logic [31:0] mem [256];
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;

  always #10 clk = ~clk;

  acc_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  function automatic logic [31:0] ins(input logic [3:0] op, input int addr);
    return {op, 28'(addr)};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h1: return "R3";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = MARK;
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    wr_cnt = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0;
    #1;
    // R1 reset state
    chk("R1", {31'd0, halted}, 32'd0);
    chk("R1", {31'd0, mem_we}, 32'd0);
    chk("R1", 32'(mem_addr), 32'd0);

    // Vector table: LOAD a; OP b; STORE result; HALT; a STORE past the halt must never run
    for (int v = 0; v < NVEC; v++) begin
      hold_reset();
      mem[0] = ins(4'h1, 100);
      mem[1] = ins(VECS[v].op, 101);
      mem[2] = ins(4'h2, 102);
      mem[3] = ins(4'hF, 0);
      mem[4] = ins(4'h2, 103);
      mem[100] = VECS[v].a;
      mem[101] = VECS[v].b;
      run(cyc);
      chk(req_of(VECS[v].op), mem[102], VECS[v].exp);
      chk("R8", 32'(cyc), 32'd14);
      chk("R4", 32'(wr_cnt), 32'd1);
      repeat (8) @(negedge clk);
      chk("R9", mem[103], MARK);
      chk("R9", {31'd0, halted}, 32'd1);
      chk("R9", 32'(wr_cnt), 32'd1);
    end

    // Chain (B+C)*(D+E) through a temporary word; R2 fields at several addresses
    hold_reset();
    mem[0] = ins(4'h1, 20);
    mem[1] = ins(4'h3, 21);
    mem[2] = ins(4'h2, 40);
    mem[3] = ins(4'h1, 22);
    mem[4] = ins(4'h3, 23);
    mem[5] = ins(4'h5, 40);
    mem[6] = ins(4'h2, 41);
    mem[7] = ins(4'hF, 0);
    mem[20] = 32'd3; mem[21] = 32'd4; mem[22] = 32'd5; mem[23] = 32'd6;
    run(cyc);
    chk("R2", mem[40], 32'd7);
    chk("R7", mem[41], 32'd77);
    chk("R8", 32'(cyc), 32'd30);
    chk("R4", 32'(wr_cnt), 32'd2);

    // Unlisted code between loads and stores leaves acc intact (R10)
    hold_reset();
    mem[0] = ins(4'h1, 50);
    mem[1] = ins(4'h0, 51);
    mem[2] = ins(4'hA, 51);
    mem[3] = ins(4'h2, 52);
    mem[4] = ins(4'hF, 0);
    mem[50] = 32'h1234_5678; mem[51] = 32'h0BAD_F00D;
    run(cyc);
    chk("R10", mem[52], 32'h1234_5678);
    chk("R10", mem[51], 32'h0BAD_F00D);
    chk("R8", 32'(cyc), 32'd18);

    // Halt as first word, then asynchronous reset clears halted (R1, R9)
    hold_reset();
    mem[0] = ins(4'hF, 0);
    run(cyc);
    chk("R9", 32'(cyc), 32'd2);
    chk("R9", 32'(wr_cnt), 32'd0);
    #2 rst_n = 1'b0;
    #1;
    chk("R1", {31'd0, halted}, 32'd0);
    chk("R1", 32'(mem_addr), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule